// File: doc/BRIEF.md
# Paged Physical Address Former

This block turns a 16-bit logical address into a 19-bit physical address by prefixing three page bits. The page bits are chosen by the class of the access: instruction fetches and branch targets use the code-page field of the status word, ordinary data accesses use the data-page field, stack accesses use the stack-page field, and cross-page moves use the low bits of a separate other-page register. Eight pages of 64K bytes are therefore reachable, with code, data and stack able to sit in different pages, much as segments do.

The block keeps the 16-bit status word and the other-page register itself. It applies the page-control commands: set data page, set stack page, set other page, and the page jump and page return that change the code page and load the program counter in the same cycle. A byte-access flag goes out beside the address. A word request at an odd address is refused and flagged instead of being issued.

Top module: `page_addr_gen`

## Requirements
- R1: While rst_n is low, and after it is released, status_q, other_q, phys_addr, addr_vld, align_err, byte_out, pc_load and pc_target are all zero until a request or command changes them.
- R2: A request with kind=0 (code fetch or branch) gives phys_addr = {status_q[15:13], laddr} with addr_vld high on the clock edge after the request is sampled.
- R3: A request with kind=1 (data) gives phys_addr = {status_q[12:10], laddr} one cycle later.
- R4: A request with kind=2 (stack) gives phys_addr = {status_q[9:7], laddr} one cycle later.
- R5: A request with kind=3 (cross-page move) gives phys_addr = {other_q[2:0], laddr} one cycle later.
- R6: A request with byte_acc high is issued at any address, odd addresses included, and raises byte_out in the same cycle as its address; a word request leaves byte_out low.
- R7: A word request (byte_acc low) with laddr[0]=1 raises align_err for one cycle, keeps addr_vld low and leaves phys_addr at its previous value.
- R8: cmd=1 (set data page) writes page_arg into status_q[12:10] and cmd=2 (set stack page) writes it into status_q[9:7]; every other status bit keeps its value.
- R9: cmd=3 (set other page) loads other_q with page_arg zero-extended to 16 bits and leaves status_q unchanged.
- R10: cmd=4 (page jump) writes page_arg into status_q[15:13], raises pc_load for exactly one cycle and presents cmd_target on pc_target in that cycle; the next code request uses the new page.
- R11: cmd=5 (page return) restores page_arg into status_q[15:13] and loads the PC with cmd_target exactly as R10 does.
- R12: status_wr high loads status_q with status_din on the next edge, and later requests use its page fields.
- R13: A cycle without a request leaves addr_vld and align_err low and byte_out low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Memory access request |
| kind | input | 2 | Access class: 0 code, 1 data, 2 stack, 3 cross-page |
| laddr | input | 16 | Logical address |
| byte_acc | input | 1 | High for a byte access |
| cmd | input | 3 | Page command: 0 none, 1 data page, 2 stack page, 3 other page, 4 page jump, 5 page return |
| page_arg | input | 3 | Page number carried by a command |
| cmd_target | input | 16 | PC value for page jump and page return |
| status_wr | input | 1 | Load the whole status word |
| status_din | input | 16 | Status word to load |
| status_q | output | 16 | Current status word |
| other_q | output | 16 | Current other-page register |
| phys_addr | output | 19 | Physical address |
| addr_vld | output | 1 | phys_addr carries a new access this cycle |
| byte_out | output | 1 | Issued access is byte wide |
| align_err | output | 1 | Word request at an odd address was refused |
| pc_load | output | 1 | Load the PC from pc_target |
| pc_target | output | 16 | New PC value |

## Verification
Every result of this block is due on the first rising edge after its request or command is sampled: the address, its valid, byte and alignment flags, the updated status and other-page registers and the PC load pulse all come out of a single register stage. The bench drives inputs on the falling edge, records what that edge should produce, and the monitor compares it one nanosecond after the next rising edge, so each expectation is matched to exactly one edge. Page values used by an access are the ones held before that edge. Commands and accesses are therefore placed on separate cycles, and a code fetch follows each page jump to show the new page taking effect.

// File: rtl/page_addr_gen.sv
module page_addr_gen #(
  parameter int LAW = 16,
  parameter int PGW = 3,
  parameter int SRW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [1:0]           kind,
  input  logic [LAW-1:0]       laddr,
  input  logic                 byte_acc,
  input  logic [2:0]           cmd,
  input  logic [PGW-1:0]       page_arg,
  input  logic [LAW-1:0]       cmd_target,
  input  logic                 status_wr,
  input  logic [SRW-1:0]       status_din,
  output logic [SRW-1:0]       status_q,
  output logic [LAW-1:0]       other_q,
  output logic [LAW+PGW-1:0]   phys_addr,
  output logic                 addr_vld,
  output logic                 byte_out,
  output logic                 align_err,
  output logic                 pc_load,
  output logic [LAW-1:0]       pc_target
);
  localparam int CODE_LSB  = SRW - PGW;
  localparam int DATA_LSB  = CODE_LSB - PGW;
  localparam int STACK_LSB = DATA_LSB - PGW;

  localparam logic [2:0] C_DPG = 3'd1;
  localparam logic [2:0] C_SPG = 3'd2;
  localparam logic [2:0] C_OPG = 3'd3;
  localparam logic [2:0] C_JMP = 3'd4;
  localparam logic [2:0] C_RET = 3'd5;

  logic [PGW-1:0] page_sel;
  logic           odd_word;
  logic           issue;
  logic           jump;
  logic [SRW-1:0] status_nx;

  always_comb begin
    case (kind)
      2'd0:    page_sel = status_q[CODE_LSB +: PGW];
      2'd1:    page_sel = status_q[DATA_LSB +: PGW];
      2'd2:    page_sel = status_q[STACK_LSB +: PGW];
      default: page_sel = other_q[PGW-1:0];
    endcase
  end

  assign odd_word = req & ~byte_acc & laddr[0];
  assign issue    = req & ~odd_word;
  assign jump     = (cmd == C_JMP) | (cmd == C_RET);

  always_comb begin
    status_nx = status_wr ? status_din : status_q;
    case (cmd)
      C_DPG:        status_nx[DATA_LSB +: PGW]  = page_arg;
      C_SPG:        status_nx[STACK_LSB +: PGW] = page_arg;
      C_JMP, C_RET: status_nx[CODE_LSB +: PGW]  = page_arg;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      other_q   <= '0;
      phys_addr <= '0;
      addr_vld  <= 1'b0;
      byte_out  <= 1'b0;
      align_err <= 1'b0;
      pc_load   <= 1'b0;
      pc_target <= '0;
    end else begin
      status_q  <= status_nx;
      addr_vld  <= issue;
      byte_out  <= req & byte_acc;
      align_err <= odd_word;
      pc_load   <= jump;
      if (issue) phys_addr <= {page_sel, laddr};
      if (jump) pc_target <= cmd_target;
      if (cmd == C_OPG) other_q <= {{(LAW-PGW){1'b0}}, page_arg};
    end
  end

  assert_code_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req && kind == 2'd0 && (byte_acc || !laddr[0]) |=>
      addr_vld && phys_addr[LAW +: PGW] == $past(status_q[CODE_LSB +: PGW]));

  assert_odd_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    odd_word |=> align_err && !addr_vld && $stable(phys_addr));

  assert_field_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_DPG && !status_wr |=>
      status_q[CODE_LSB +: PGW] == $past(status_q[CODE_LSB +: PGW]) &&
      status_q[DATA_LSB-1:0] == $past(status_q[DATA_LSB-1:0]));

  assert_jump_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_JMP |=> pc_load && pc_target == $past(cmd_target));

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_vld && !align_err && !byte_out);

  assert_one_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_vld && align_err));
endmodule

// File: tb/page_addr_gen_tb.sv
module page_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = '0;
  logic [15:0] laddr = '0;
  logic        byte_acc = 1'b0;
  logic [2:0]  cmd = '0;
  logic [2:0]  page_arg = '0;
  logic [15:0] cmd_target = '0;
  logic        status_wr = 1'b0;
  logic [15:0] status_din = '0;
  logic [15:0] status_q, other_q, pc_target;
  logic [18:0] phys_addr;
  logic        addr_vld, byte_out, align_err, pc_load;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [18:0] addr;
    logic        vld, bo, err, pcl;
    logic [15:0] sr, odp, pct;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [15:0] m_sr = '0, m_odp = '0, m_pct = '0;
  logic [18:0] m_addr = '0;

  always #10 clk = ~clk;

  page_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .kind(kind), .laddr(laddr),
    .byte_acc(byte_acc), .cmd(cmd), .page_arg(page_arg), .cmd_target(cmd_target),
    .status_wr(status_wr), .status_din(status_din), .status_q(status_q),
    .other_q(other_q), .phys_addr(phys_addr), .addr_vld(addr_vld),
    .byte_out(byte_out), .align_err(align_err), .pc_load(pc_load),
    .pc_target(pc_target)
  );

  task automatic step(input logic r, input logic [1:0] k, input logic [15:0] a,
                      input logic b, input logic [2:0] c, input logic [2:0] p,
                      input logic [15:0] t, input logic w, input logic [15:0] d,
                      input string tag);
    exp_t e;
    logic [2:0] pg;
    @(negedge clk);
    req = r; kind = k; laddr = a; byte_acc = b; cmd = c; page_arg = p;
    cmd_target = t; status_wr = w; status_din = d;
    case (k)
      2'd0: pg = m_sr[15:13];
      2'd1: pg = m_sr[12:10];
      2'd2: pg = m_sr[9:7];
      default: pg = m_odp[2:0];
    endcase
    e.vld = r && (b || !a[0]);
    e.err = r && !b && a[0];
    e.bo  = r && b;
    if (e.vld) m_addr = {pg, a};
    e.addr = m_addr;
    if (w) m_sr = d;
    if (c == 3'd1) m_sr[12:10] = p;
    if (c == 3'd2) m_sr[9:7] = p;
    if (c == 3'd4 || c == 3'd5) begin m_sr[15:13] = p; m_pct = t; end
    if (c == 3'd3) m_odp = {13'd0, p};
    e.pcl = (c == 3'd4 || c == 3'd5);
    e.sr = m_sr; e.odp = m_odp; e.pct = m_pct; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (phys_addr !== e.addr || addr_vld !== e.vld || byte_out !== e.bo ||
            align_err !== e.err || pc_load !== e.pcl || status_q !== e.sr ||
            other_q !== e.odp || pc_target !== e.pct) begin
          bad++;
          $display("FAIL %s: got addr=%h v=%b b=%b e=%b pl=%b sr=%h odp=%h pt=%h exp addr=%h v=%b b=%b e=%b pl=%b sr=%h odp=%h pt=%h",
            e.tag, phys_addr, addr_vld, byte_out, align_err, pc_load, status_q, other_q, pc_target,
            e.addr, e.vld, e.bo, e.err, e.pcl, e.sr, e.odp, e.pct);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got no finish, exp finish within 5000 cycles");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (status_q !== 0 || other_q !== 0 || phys_addr !== 0 || addr_vld !== 0 ||
        byte_out !== 0 || align_err !== 0 || pc_load !== 0 || pc_target !== 0) begin
      bad++;
      $display("FAIL R1: got sr=%h odp=%h addr=%h v=%b exp all zero", status_q, other_q, phys_addr, addr_vld);
    end
    rst_n = 1'b1;
    step(0, 0, 16'h0000, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
    step(1, 0, 16'h0020, 0, 0, 0, 0, 0, 0, "R2 fetch page 0");
    step(0, 0, 0, 0, 0, 0, 0, 1, {3'd5, 3'd3, 3'd6, 7'h55}, "R12 load status");
    step(1, 0, 16'h1234, 0, 0, 0, 0, 0, 0, "R2 fetch page 5");
    step(1, 1, 16'h8000, 0, 0, 0, 0, 0, 0, "R3 data page 3");
    step(1, 2, 16'hFFFE, 0, 0, 0, 0, 0, 0, "R4 stack page 6");
    step(0, 0, 0, 0, 3'd3, 3'd7, 0, 0, 0, "R9 set other page 7");
    step(1, 3, 16'h0100, 0, 0, 0, 0, 0, 0, "R5 cross-page access");
    step(1, 1, 16'h0101, 1, 0, 0, 0, 0, 0, "R6 odd byte access");
    step(1, 1, 16'h0202, 1, 0, 0, 0, 0, 0, "R6 even byte access");
    step(1, 2, 16'h0303, 0, 0, 0, 0, 0, 0, "R7 odd word refused");
    step(1, 0, 16'h0FFF, 0, 0, 0, 0, 0, 0, "R7 odd word fetch refused");
    step(0, 1, 16'h0404, 0, 0, 0, 0, 0, 0, "R13 no request");
    step(0, 0, 0, 0, 3'd1, 3'd2, 0, 0, 0, "R8 set data page");
    step(0, 0, 0, 0, 3'd2, 3'd4, 0, 0, 0, "R8 set stack page");
    step(1, 1, 16'h5000, 0, 0, 0, 0, 0, 0, "R3 data on new page");
    step(1, 2, 16'h6000, 0, 0, 0, 0, 0, 0, "R4 stack on new page");
    step(0, 0, 0, 0, 3'd4, 3'd6, 16'h4000, 0, 0, "R10 page jump");
    step(1, 0, 16'h4000, 0, 0, 0, 0, 0, 0, "R10 fetch after jump");
    step(0, 0, 0, 0, 3'd5, 3'd1, 16'h0456, 0, 0, "R11 page return");
    step(1, 0, 16'h0456, 0, 0, 0, 0, 0, 0, "R11 fetch after return");
    step(0, 0, 0, 0, 3'd3, 3'd0, 0, 0, 0, "R9 other page back to 0");
    step(1, 3, 16'hABCC, 0, 0, 0, 0, 0, 0, "R5 cross-page on page 0");
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFF, "R12 load all ones");
    step(1, 1, 16'h0010, 0, 0, 0, 0, 0, 0, "R12 data uses loaded page");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R13 idle tail");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule